// File: doc/BRIEF.md
# Configuration Fallback Strike Controller

This block decides where each configuration attempt of a reprogrammable device starts, and when to stop trying. Three stored images are involved: a header image that always sits at address zero, a primary image at a programmable address, and a golden (known-good) image at a second programmable address. Configuration errors, either a CRC failure reported by the load path or a timeout of the internal sync watchdog, add one to a single shared strike count. The controller then either retries, moves on to another image, or halts. The halt state holds both the init and done indications low.

A single counter drives every choice through cumulative thresholds. Below three strikes an image is retried. At three, the primary gives way to the golden image. At six, the golden image wraps back to address zero. At nine, everything stops. Each decision is a one-cycle reconfigure-request pulse together with a registered 24-bit start address. A soft reprogram request (from the running design, or embedded in the header after sync) restarts at the primary address. After a golden image has booted successfully, a soft reprogram request restarts at the golden address instead, and the strike count is left untouched. Only a hard reset or power-on clears the strike count.

The flash read engine and the CRC computation are outside the block. They report to it through single-cycle event inputs.

Top module: `fbk_strike_ctrl`

## Requirements
- R1: Each cycle in the loading state with a CRC error or a watchdog timeout (or both) raises the strike count by exactly one. Errors outside the loading state are not counted.
- R2: On an error while the header image (image code 0) loads, the next attempt restarts at address 0 while the new count is below 3. A CRC error restarts only when the reset-on-error flag is 1, but a watchdog timeout restarts regardless of that flag. At a count of 3, or on a CRC error with the flag at 0, the block halts.
- R3: On an error while the primary image (image code 1) loads before the wrap, the next attempt uses the primary address while the new count is below 3. At 3 or more the next attempt uses the golden address (image code 2).
- R4: On an error while the golden image loads, the next attempt uses the golden address while the new count is below 6. At 6 (and at 7 or 8) it restarts at address 0 with image code 0.
- R5: Once the count is 6 or more, an error on the primary image sends the next attempt to the golden address. When the new count reaches 9, the block halts.
- R6: The watchdog runs only in master mode, in the loading state, and only until sync is seen. Its limit is the 16-bit load value, clamped to at least 0x0202. A timeout restarts the watchdog, and consecutive timeouts are spaced limit+1 cycles apart.
- R7: In the halted state, init_b and done are both low and stay low until hard reset. Further error, sync, startup and reprogram events change nothing.
- R8: The strike count is cleared only by power-on reset or the hard reset input. A soft reprogram request leaves it unchanged.
- R9: After startup completes on the golden image, a soft reprogram request starts at the golden address. A reprogram request while the golden image is loading is ignored.
- R10: When encryption is enabled or the device is in slave mode (master low), any error halts the block, and the count is still incremented.
- R11: Every decision to load produces a one-cycle reconf pulse, during which init_b is low, with the registered start address and image code. Startup done in the loading state raises done. A soft reprogram request is accepted from the running state, or from the header after sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low power-on reset |
| hard_rst_i | input | 1 | Hard reboot request (program pulse), clears all state |
| crc_err_i | input | 1 | CRC error pulse from the load path |
| sync_det_i | input | 1 | Sync word detected pulse |
| eos_i | input | 1 | Startup sequence finished pulse |
| iprog_i | input | 1 | Soft reprogram request pulse |
| reset_on_err_i | input | 1 | Allow retry after a CRC error |
| master_i | input | 1 | 1 = master configuration mode, 0 = slave |
| encrypt_i | input | 1 | Bitstream encryption enabled |
| pri_addr_i | input | 24 | Primary image start address |
| gld_addr_i | input | 24 | Golden image start address |
| wdt_load_i | input | 16 | Watchdog load value in clocks |
| start_addr_o | output | 24 | Registered start address of the current attempt |
| reconf_o | output | 1 | One-cycle reconfigure request |
| image_o | output | 2 | Image of the current attempt: 0 header, 1 primary, 2 golden |
| init_b_o | output | 1 | Init indication, low while halted or during reconf |
| done_o | output | 1 | Configuration done indication |
| halted_o | output | 1 | Block has halted |
| strikes_o | output | 4 | Shared strike count |

## Verification
The bench builds the block with its default parameters: thresholds 3, 6 and 9, a 4-bit strike counter, a 16-bit watchdog with a 0x0202 floor, and 24-bit addresses. With these values the entire climb from zero to the final halt at nine strikes, including the wrap to the header, fits in a few dozen cycles driven by CRC pulses. The clamped watchdog limit is short enough that timeout spacing can be measured exactly, both at the floor and just above it. Slave and encrypted runs exercise the immediate-halt path.

// File: rtl/fbk_pkg.sv
package fbk_pkg;

    typedef enum logic [1:0] {
        IMG_HDR = 2'd0,
        IMG_PRI = 2'd1,
        IMG_GLD = 2'd2
    } img_e;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } st_e;

endpackage

// File: rtl/fbk_watchdog.sv
module fbk_watchdog #(
    parameter int          WDT_W   = 16,
    parameter logic [15:0] WDT_MIN = 16'h0202
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             arm_i,
    input  logic [WDT_W-1:0] load_i,
    output logic             timeout_o
);
    localparam logic [WDT_W-1:0] FLOOR = WDT_W'(WDT_MIN);

    logic [WDT_W-1:0] lim;
    logic [WDT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        lim   = (load_i < FLOOR) ? FLOOR : load_i;
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (arm_i && (cnt_q != lim)) begin
            cnt_d = cnt_q + 1'b1;
        end
        timeout_o = arm_i && (cnt_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_WDT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (cnt_q >= FLOOR)); // R6
    AST_WDT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !clr_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/fbk_decide.sv
module fbk_decide
    import fbk_pkg::*;
#(
    parameter int SW    = 4,
    parameter int LIM_A = 3,
    parameter int LIM_B = 6,
    parameter int LIM_C = 9
) (
    input  img_e          img_i,
    input  logic [SW-1:0] strikes_i,
    input  logic          crc_only_i,
    input  logic          fb_ok_i,
    input  logic          reset_on_err_i,
    output logic          halt_o,
    output img_e          tgt_o,
    output logic [SW-1:0] next_strikes_o
);
    localparam logic [SW-1:0] SMAX = '1;
    localparam logic [SW-1:0] LA   = SW'(LIM_A);
    localparam logic [SW-1:0] LB   = SW'(LIM_B);
    localparam logic [SW-1:0] LC   = SW'(LIM_C);

    logic [SW-1:0] n;

    always_comb begin
        n      = (strikes_i == SMAX) ? SMAX : strikes_i + 1'b1;
        halt_o = 1'b0;
        tgt_o  = img_i;
        if (!fb_ok_i) begin
            halt_o = 1'b1;
        end else if (crc_only_i && !reset_on_err_i) begin
            halt_o = 1'b1;
        end else begin
            case (img_i)
                IMG_HDR: begin
                    if (n >= LA) halt_o = 1'b1;
                    else         tgt_o  = IMG_HDR;
                end
                IMG_PRI: begin
                    if (strikes_i < LB) begin
                        tgt_o = (n < LA) ? IMG_PRI : IMG_GLD;
                    end else if (n >= LC) begin
                        halt_o = 1'b1;
                    end else begin
                        tgt_o = IMG_GLD;
                    end
                end
                IMG_GLD: begin
                    if (n < LB)      tgt_o  = IMG_GLD;
                    else if (n < LC) tgt_o  = IMG_HDR;
                    else             halt_o = 1'b1;
                end
                default: halt_o = 1'b1;
            endcase
        end
        next_strikes_o = n;
    end

endmodule

// File: rtl/fbk_strike_ctrl.sv
module fbk_strike_ctrl
    import fbk_pkg::*;
#(
    parameter int          AW      = 24,
    parameter int          SW      = 4,
    parameter int          WDT_W   = 16,
    parameter logic [15:0] WDT_MIN = 16'h0202,
    parameter int          LIM_A   = 3,
    parameter int          LIM_B   = 6,
    parameter int          LIM_C   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_rst_i,
    input  logic             crc_err_i,
    input  logic             sync_det_i,
    input  logic             eos_i,
    input  logic             iprog_i,
    input  logic             reset_on_err_i,
    input  logic             master_i,
    input  logic             encrypt_i,
    input  logic [AW-1:0]    pri_addr_i,
    input  logic [AW-1:0]    gld_addr_i,
    input  logic [WDT_W-1:0] wdt_load_i,
    output logic [AW-1:0]    start_addr_o,
    output logic             reconf_o,
    output logic [1:0]       image_o,
    output logic             init_b_o,
    output logic             done_o,
    output logic             halted_o,
    output logic [SW-1:0]    strikes_o
);
    typedef struct packed {
        st_e           st;
        img_e          img;
        logic [SW-1:0] strikes;
        logic [AW-1:0] addr;
        logic          reconf;
        logic          synced;
        logic          gold_boot;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_LOAD, img: IMG_HDR, strikes: '0,
                                 addr: '0, reconf: 1'b0, synced: 1'b0,
                                 gold_boot: 1'b0};

    ctl_t ctl_d, ctl_q;

    logic          wdt_to;
    logic          wdt_arm;
    logic          wdt_clr;
    logic          loading;
    logic          err;
    logic          dec_halt;
    img_e          dec_tgt;
    logic [SW-1:0] dec_strikes;

    function automatic logic [AW-1:0] addr_of(input img_e im,
                                              input logic [AW-1:0] pa,
                                              input logic [AW-1:0] ga);
        case (im)
            IMG_PRI: addr_of = pa;
            IMG_GLD: addr_of = ga;
            default: addr_of = '0;
        endcase
    endfunction

    assign loading = (ctl_q.st == ST_LOAD);
    assign err     = loading && (crc_err_i || wdt_to);
    assign wdt_arm = loading && master_i && !ctl_q.synced;

    fbk_decide #(
        .SW    (SW),
        .LIM_A (LIM_A),
        .LIM_B (LIM_B),
        .LIM_C (LIM_C)
    ) u_decide (
        .img_i          (ctl_q.img),
        .strikes_i      (ctl_q.strikes),
        .crc_only_i     (crc_err_i && !wdt_to),
        .fb_ok_i        (master_i && !encrypt_i),
        .reset_on_err_i (reset_on_err_i),
        .halt_o         (dec_halt),
        .tgt_o          (dec_tgt),
        .next_strikes_o (dec_strikes)
    );

    always_comb begin
        img_e soft_tgt;
        ctl_d        = ctl_q;
        ctl_d.reconf = 1'b0;
        soft_tgt     = ctl_q.gold_boot ? IMG_GLD : IMG_PRI;
        if (hard_rst_i) begin
            ctl_d = CTL_RST;
        end else begin
            case (ctl_q.st)
                ST_LOAD: begin
                    if (err) begin
                        ctl_d.strikes = dec_strikes;
                        if (dec_halt) begin
                            ctl_d.st = ST_HALT;
                        end else begin
                            ctl_d.reconf = 1'b1;
                            ctl_d.img    = dec_tgt;
                            ctl_d.addr   = addr_of(dec_tgt, pri_addr_i, gld_addr_i);
                            ctl_d.synced = 1'b0;
                        end
                    end else if (eos_i) begin
                        ctl_d.st = ST_RUN;
                        if (ctl_q.img == IMG_GLD) ctl_d.gold_boot = 1'b1;
                    end else if (iprog_i && (ctl_q.img == IMG_HDR) && ctl_q.synced) begin
                        ctl_d.reconf = 1'b1;
                        ctl_d.img    = soft_tgt;
                        ctl_d.addr   = addr_of(soft_tgt, pri_addr_i, gld_addr_i);
                        ctl_d.synced = 1'b0;
                    end else if (sync_det_i) begin
                        ctl_d.synced = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (iprog_i) begin
                        ctl_d.st     = ST_LOAD;
                        ctl_d.reconf = 1'b1;
                        ctl_d.img    = soft_tgt;
                        ctl_d.addr   = addr_of(soft_tgt, pri_addr_i, gld_addr_i);
                        ctl_d.synced = 1'b0;
                    end
                end
                default: begin
                    ctl_d.st = ST_HALT;
                end
            endcase
        end
    end

    assign wdt_clr = ctl_d.reconf || hard_rst_i;

    fbk_watchdog #(
        .WDT_W   (WDT_W),
        .WDT_MIN (WDT_MIN)
    ) u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (wdt_clr),
        .arm_i     (wdt_arm),
        .load_i    (wdt_load_i),
        .timeout_o (wdt_to)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_addr_o = ctl_q.addr;
    assign reconf_o     = ctl_q.reconf;
    assign image_o      = ctl_q.img;
    assign halted_o     = (ctl_q.st == ST_HALT);
    assign init_b_o     = !halted_o && !ctl_q.reconf;
    assign done_o       = (ctl_q.st == ST_RUN);
    assign strikes_o    = ctl_q.strikes;

    AST_STRIKE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hard_rst_i |=> ((ctl_q.strikes == $past(ctl_q.strikes)) ||
                         (ctl_q.strikes == SW'($past(ctl_q.strikes) + 1'b1)))); // R1
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_HALT) && !hard_rst_i) |=> (ctl_q.st == ST_HALT)); // R7
    AST_SOFT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_RUN) && iprog_i && !hard_rst_i) |=> $stable(ctl_q.strikes)); // R8
    AST_SOFT_TO_GOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_RUN) && ctl_q.gold_boot && iprog_i && !hard_rst_i)
        |=> (ctl_q.reconf && (ctl_q.img == IMG_GLD))); // R9
    AST_HDR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.reconf && (ctl_q.img == IMG_HDR)) |-> (ctl_q.addr == '0)); // R4
    AST_NO_PULSE_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HALT) |=> !ctl_q.reconf); // R11

endmodule

// File: tb/fbk_strike_ctrl_bench.sv
`timescale 1ns/1ps
module fbk_strike_ctrl_bench;
    localparam logic [23:0] PRI = 24'h12_3400;
    localparam logic [23:0] GLD = 24'h45_6700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hard_rst = 1'b0, crc = 1'b0, sync = 1'b0, eos = 1'b0, iprog = 1'b0;
    logic        roe = 1'b1, master = 1'b1, encrypt = 1'b0;
    logic [15:0] wdt_load = 16'hFFFF;
    logic [23:0] start_addr;
    logic        reconf, init_b, done, halted;
    logic [1:0]  image;
    logic [3:0]  strikes;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fbk_strike_ctrl u_fbk_strike_ctrl (
        .clk(clk), .rst_n(rst_n), .hard_rst_i(hard_rst), .crc_err_i(crc),
        .sync_det_i(sync), .eos_i(eos), .iprog_i(iprog), .reset_on_err_i(roe),
        .master_i(master), .encrypt_i(encrypt), .pri_addr_i(PRI), .gld_addr_i(GLD),
        .wdt_load_i(wdt_load), .start_addr_o(start_addr), .reconf_o(reconf),
        .image_o(image), .init_b_o(init_b), .done_o(done), .halted_o(halted),
        .strikes_o(strikes)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // 0 crc, 1 sync, 2 eos, 3 iprog, 4 hard reset
    task automatic fire(input int sel);
        @(negedge clk);
        case (sel)
            0: crc = 1'b1;
            1: sync = 1'b1;
            2: eos = 1'b1;
            3: iprog = 1'b1;
            default: hard_rst = 1'b1;
        endcase
        @(negedge clk);
        crc = 1'b0; sync = 1'b0; eos = 1'b0; iprog = 1'b0; hard_rst = 1'b0;
    endtask

    task automatic expect_load(input string tag, input int s, input logic [23:0] a, input int im);
        chk(tag, "reconf", reconf, 1);
        chk(tag, "strikes", strikes, s);
        chk(tag, "addr", start_addr, a);
        chk(tag, "image", image, im);
        chk(tag, "halted", halted, 0);
    endtask

    task automatic expect_halt(input string tag, input int s);
        chk(tag, "halted", halted, 1);
        chk(tag, "init_b", init_b, 0);
        chk(tag, "done", done, 0);
        chk(tag, "strikes", strikes, s);
    endtask

    task automatic gap(output int c);
        int g = 0;
        while (!reconf && g < 3000) begin @(negedge clk); g++; end
        c = 0;
        do begin @(negedge clk); c++; end while (!reconf && c < 3000);
    endtask

    task automatic t_reset;
        chk("R8", "reset strikes", strikes, 0);
        chk("R11", "reset addr", start_addr, 0);
        chk("R11", "reset reconf", reconf, 0);
        chk("R7", "reset init_b", init_b, 1);
        chk("R11", "reset done", done, 0);
        chk("R7", "reset halted", halted, 0);
    endtask

    task automatic t_header_crc;
        fire(4); roe = 1'b1;
        fire(0); expect_load("R2", 1, 24'h0, 0);
        chk("R11", "init_b low in reconf", init_b, 0);
        @(negedge clk); chk("R11", "reconf one cycle", reconf, 0);
        fire(0); expect_load("R2", 2, 24'h0, 0);
        fire(0); expect_halt("R2", 3);
        fire(0); expect_halt("R7", 3);
        fire(3); fire(2); repeat (40) @(negedge clk);
        expect_halt("R7", 3);
        fire(4); chk("R8", "hard reset clears", strikes, 0);
        chk("R8", "hard reset unhalts", halted, 0);
        roe = 1'b0;
        fire(0); expect_halt("R2", 1);
        roe = 1'b1;
    endtask

    task automatic t_full_chain;
        fire(4);
        fire(1); fire(2); chk("R11", "done after eos", done, 1);
        fire(3); expect_load("R11", 0, PRI, 1);
        chk("R11", "done drops", done, 0);
        fire(0); expect_load("R3", 1, PRI, 1);
        fire(0); expect_load("R3", 2, PRI, 1);
        fire(0); expect_load("R3", 3, GLD, 2);
        fire(0); expect_load("R4", 4, GLD, 2);
        fire(0); expect_load("R4", 5, GLD, 2);
        fire(0); expect_load("R4", 6, 24'h0, 0);
        fire(1); fire(3); expect_load("R11", 6, PRI, 1);
        fire(0); expect_load("R5", 7, GLD, 2);
        fire(0); expect_load("R5", 8, 24'h0, 0);
        fire(1); fire(3); expect_load("R5", 8, PRI, 1);
        fire(0); expect_halt("R5", 9);
    endtask

    task automatic t_golden_boot;
        fire(4);
        fire(1); fire(2); fire(3);
        fire(0); fire(0); fire(0); expect_load("R3", 3, GLD, 2);
        fire(1); fire(3);
        chk("R9", "iprog ignored in golden load", reconf, 0);
        chk("R9", "image kept", image, 2);
        fire(2); chk("R11", "done on golden", done, 1);
        chk("R8", "count kept after fallback", strikes, 3);
        fire(3); expect_load("R9", 3, GLD, 2);
        chk("R8", "soft reboot keeps count", strikes, 3);
    endtask

    task automatic t_watchdog;
        int c;
        bit seen;
        roe = 1'b0; wdt_load = 16'h0010;
        fire(4);
        gap(c);
        chk("R6", "clamped spacing", c, 515);
        expect_load("R2", 2, 24'h0, 0);
        fire(1);
        seen = 0;
        repeat (700) begin @(negedge clk); if (reconf) seen = 1; end
        chk("R6", "no timeout after sync", seen, 0);
        chk("R6", "count after sync", strikes, 2);
        wdt_load = 16'h0210;
        fire(4);
        gap(c);
        chk("R6", "spacing above floor", c, 529);
        chk("R1", "timeouts counted", strikes, 2);
        fire(4); wdt_load = 16'hFFFF; roe = 1'b1;
    endtask

    task automatic t_no_fallback;
        bit seen;
        master = 1'b0; wdt_load = 16'h0010;
        fire(4);
        seen = 0;
        repeat (1000) begin @(negedge clk); if (reconf) seen = 1; end
        chk("R6", "no watchdog in slave", seen, 0);
        chk("R6", "slave count", strikes, 0);
        fire(0); expect_halt("R10", 1);
        master = 1'b1; encrypt = 1'b1; wdt_load = 16'hFFFF;
        fire(4);
        fire(1); fire(2); fire(3);
        fire(0); expect_halt("R10", 1);
        encrypt = 1'b0;
        fire(4);
        fire(2); fire(0);
        chk("R1", "error outside load ignored", strikes, 0);
        chk("R1", "still running", done, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_header_crc();
        t_full_chain();
        t_golden_boot();
        t_watchdog();
        t_no_fallback();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule